// File: doc/BRIEF.md
# Serial NOR Flash Page-Program Sequencer

This block takes a single host request, made up of a start byte address, a byte count and a stream of data bytes, and turns it into the series of program transactions a serial NOR flash expects on a single-lane bus. It cuts the request into chunks so that no chunk reaches past the end of a 256-byte page. It opens each chunk with a write-enable command and confirms that command with one status read. It then sends the program opcode, the address and the chunk's bytes. After that it keeps reading status until the flash reports that its internal write is over, and only then moves on to the next chunk.

The bus side is a byte-level shifter handshake. The block strobes one byte at a time into an external serial shifter, waits for the shifter's completion pulse with the byte received, and drives chip select itself. Each command has its own select window. The host side offers start, address and length, a valid/ready byte stream, and the status outputs busy, done and error. An error is raised when the flash does not report writes enabled after the enable command. It is also raised when a write stays in progress longer than a parameterised number of clock cycles. At the default 100 MHz that limit is 1 ms, which is above the 0.75 ms worst-case page program time.

Top module: `spi_page_writer`

## Requirements
- R1: After reset, busy, done, error, in_ready and sh_start are 0 and flash_cs_n is 1.
- R2: Each chunk uses four commands in this order: write enable (one byte, 06h); a status read (05h followed by one dummy byte, with the status returned in the second byte); program (02h, then the address as three bytes with the most significant byte first, then the chunk data); and one or more status reads (05h plus a dummy byte).
- R3: No program command carries data past a 256-byte aligned page. The first chunk length is min(length, 256 − (address mod 256)). Each later chunk length is min(remaining, 256), and the address advances by the chunk length.
- R4: Every command runs inside its own select window, with flash_cs_n low for the whole command. flash_cs_n returns high for at least one cycle between commands. sh_start pulses only while flash_cs_n is low. A new byte strobe waits for sh_done from the previous one.
- R5: If status bit 1 (write-enable latch) reads 0 in the check after write enable, the block pulses error, sends no program opcode and drops busy.
- R6: The block repeats status polls while status bit 0 (write in progress) reads 1. When it reads 0, the block starts the next chunk, or pulses done after the last chunk.
- R7: If status bit 0 still reads 1 after TIMEOUT_CYC cycles of polling for one chunk, the block pulses error and drops busy.
- R8: Data bytes go out in stream order. A byte is taken only when in_valid and in_ready are both high. in_ready is high only in a data slot of a program command, which means while selected. A low in_valid stalls the command without sending a byte.
- R9: A start with length 0 pulses done one cycle later, with no bus activity and without raising busy.
- R10: A start pulse while busy is ignored.
- R11: done and error are single-cycle pulses and never high together. busy falls on exactly the edge where one of them rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, taken only when idle |
| start_addr | input | 8*ADDR_BYTES | First byte address of the write |
| start_len | input | LEN_W | Number of bytes to write |
| in_data | input | 8 | Host data byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Block takes in_data this cycle when in_valid is high |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when all chunks have been written |
| error | output | 1 | One-cycle pulse when the request is abandoned |
| flash_cs_n | output | 1 | Flash chip select, active low |
| sh_start | output | 1 | Strobe: shift sh_tx out on the bus |
| sh_tx | output | 8 | Byte to transmit |
| sh_done | input | 1 | Shifter finished the byte |
| sh_rx | input | 8 | Byte received while sh_tx was shifted out |

## Verification
A wrong chunk length or a wrong address update shows up at the flash port as soon as the first program command after the fault closes. The data lands on the wrong page, or the burst crosses a page boundary, and the responder catches either within a few hundred cycles. A lost write-enable check or a skipped poll changes the order of opcodes inside that same chunk. A wrong byte counter shifts data against addresses, so the memory image differs when the request ends. A bad error path shows in the pulse seen on done or error when a run ends: a WEL refusal should end the run within about 20 cycles, and a stuck write should end it after about TIMEOUT_CYC cycles.

// File: rtl/spw_pkg.sv
package spw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PLAN, ST_ISSUE, ST_WAIT, ST_GAP, ST_DONE, ST_FAIL
  } spw_state_e;

  typedef enum logic [1:0] {
    PH_WREN, PH_CHECK, PH_PROG, PH_POLL
  } spw_phase_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_PP3  = 8'h02;
  localparam logic [7:0] OP_PP4  = 8'h12;
  localparam int         WIP_BIT = 0;
  localparam int         WEL_BIT = 1;
endpackage

// File: rtl/spw_chunk_plan.sv
module spw_chunk_plan #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int CHUNK_W   = PAGE_W + 1
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [LEN_W-1:0]   remaining,
  output logic [CHUNK_W-1:0] chunk_len
);
  logic [CHUNK_W-1:0] room;

  // bytes left before the next page boundary
  always_comb begin
    room = CHUNK_W'(PAGE_BYTES) - {1'b0, cur_addr[PAGE_W-1:0]};
    if (remaining < LEN_W'(room)) chunk_len = CHUNK_W'(remaining);
    else                          chunk_len = room;
  end
endmodule

// File: rtl/spw_poll_timer.sv
module spw_poll_timer #(
  parameter int TIMEOUT_CYC = 100000,
  localparam int CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt;

  assign expired = (cnt >= CNT_W'(TIMEOUT_CYC));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spw_tx_select.sv
module spw_tx_select
  import spw_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int IDX_W      = 9,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int HDR       = 1 + ADDR_BYTES
) (
  input  spw_phase_e        phase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic [7:0]        tx_byte
);
  logic [7:0] prog_op;

  generate
    if (ADDR_BYTES == 4) begin : g_wide
      assign prog_op = OP_PP4;
    end else begin : g_narrow
      assign prog_op = OP_PP3;
    end
  endgenerate

  always_comb begin
    tx_byte = 8'h00;
    case (phase)
      PH_WREN:           tx_byte = OP_WREN;
      PH_CHECK, PH_POLL: tx_byte = (idx == '0) ? OP_RDSR : 8'h00;
      default: begin
        if (idx == '0) tx_byte = prog_op;
        else if (idx >= IDX_W'(HDR)) tx_byte = data;
        else begin
          for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == IDX_W'(k + 1)) tx_byte = addr[8*(ADDR_BYTES-1-k) +: 8];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer
  import spw_pkg::*;
#(
  parameter int ADDR_BYTES  = 3,
  parameter int LEN_W       = 16,
  parameter int PAGE_BYTES  = 256,
  parameter int TIMEOUT_CYC = 100000,
  localparam int ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              flash_cs_n,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx
);
  localparam int PAGE_W  = $clog2(PAGE_BYTES);
  localparam int CHUNK_W = PAGE_W + 1;
  localparam int HDR     = 1 + ADDR_BYTES;
  localparam int IDX_W   = $clog2(HDR + PAGE_BYTES + 1);

  spw_state_e         state;
  spw_phase_e         phase;
  logic [IDX_W-1:0]   idx, last_idx;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   remaining;
  logic [CHUNK_W-1:0] chunk_q, chunk_next;
  logic [7:0]         stat_q, tx_byte;
  logic               data_slot, tmo_clear, tmo_run, tmo_expired;

  spw_chunk_plan #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_plan (
    .cur_addr(cur_addr), .remaining(remaining), .chunk_len(chunk_next)
  );

  assign tmo_clear = (state == ST_GAP) && (phase == PH_PROG);
  assign tmo_run   = busy && (phase == PH_POLL);

  spw_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .clear(tmo_clear), .run(tmo_run), .expired(tmo_expired)
  );

  spw_tx_select #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_txsel (
    .phase(phase), .idx(idx), .addr(cur_addr), .data(in_data), .tx_byte(tx_byte)
  );

  assign data_slot = (phase == PH_PROG) && (idx >= IDX_W'(HDR));
  assign in_ready  = (state == ST_ISSUE) && data_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= PH_WREN;
      idx        <= '0;
      last_idx   <= '0;
      cur_addr   <= '0;
      remaining  <= '0;
      chunk_q    <= '0;
      stat_q     <= '0;
      flash_cs_n <= 1'b1;
      sh_start   <= 1'b0;
      sh_tx      <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (start_len == '0) begin
              done <= 1'b1;
            end else begin
              busy      <= 1'b1;
              cur_addr  <= start_addr;
              remaining <= start_len;
              state     <= ST_PLAN;
            end
          end
        end
        ST_PLAN: begin
          chunk_q    <= chunk_next;
          phase      <= PH_WREN;
          idx        <= '0;
          last_idx   <= '0;
          flash_cs_n <= 1'b0;
          state      <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (!data_slot || in_valid) begin
            sh_start <= 1'b1;
            sh_tx    <= tx_byte;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (sh_done) begin
            if (idx == last_idx) begin
              stat_q     <= sh_rx;
              flash_cs_n <= 1'b1;
              state      <= ST_GAP;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        ST_GAP: begin
          idx <= '0;
          case (phase)
            PH_WREN: begin
              phase      <= PH_CHECK;
              last_idx   <= IDX_W'(1);
              flash_cs_n <= 1'b0;
              state      <= ST_ISSUE;
            end
            PH_CHECK: begin
              if (stat_q[WEL_BIT]) begin
                phase      <= PH_PROG;
                last_idx   <= IDX_W'(HDR) + IDX_W'(chunk_q) - 1'b1;
                flash_cs_n <= 1'b0;
                state      <= ST_ISSUE;
              end else begin
                state <= ST_FAIL;
              end
            end
            PH_PROG: begin
              phase      <= PH_POLL;
              last_idx   <= IDX_W'(1);
              flash_cs_n <= 1'b0;
              state      <= ST_ISSUE;
            end
            default: begin
              if (!stat_q[WIP_BIT]) begin
                cur_addr  <= cur_addr + ADDR_W'(chunk_q);
                remaining <= remaining - LEN_W'(chunk_q);
                state     <= (remaining == LEN_W'(chunk_q)) ? ST_DONE : ST_PLAN;
              end else if (tmo_expired) begin
                state <= ST_FAIL;
              end else begin
                last_idx   <= IDX_W'(1);
                flash_cs_n <= 1'b0;
                state      <= ST_ISSUE;
              end
            end
          endcase
        end
        ST_DONE: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: begin
          error      <= 1'b1;
          busy       <= 1'b0;
          flash_cs_n <= 1'b1;
          state      <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/spw_checker.sv
module spw_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [LEN_W-1:0] start_len,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic             flash_cs_n,
  input logic             sh_start,
  input logic             in_ready
);
  // R4: byte strobes only inside a select window
  p_strobe_selected_r4: assert property (@(posedge clk) disable iff (rst)
    sh_start |-> !flash_cs_n);

  // R4: no back-to-back strobes, each waits for the shifter
  p_one_byte_r4: assert property (@(posedge clk) disable iff (rst)
    sh_start |=> !sh_start);

  // R8: stream accepted only while selected
  p_ready_selected_r8: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !flash_cs_n);

  // R11: outcomes exclusive
  p_outcome_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  // R11: single-cycle done
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: busy ends only with an outcome
  p_busy_fall_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || error));

  // R9: empty request completes next cycle
  p_zero_len_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (start_len == '0)) |=> (done && !busy));
endmodule

bind spi_page_writer spw_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .start_len(start_len), .busy(busy),
  .done(done), .error(error), .flash_cs_n(flash_cs_n), .sh_start(sh_start),
  .in_ready(in_ready)
);

// File: tb/spi_page_writer_tb.sv
module spi_page_writer_tb;
  localparam int TMO       = 2000;
  localparam int POLL_BUSY = 3;
  localparam int MEM_N     = 4096;

  logic clk = 0, rst = 1;
  logic start = 0;
  logic [23:0] start_addr = '0;
  logic [15:0] start_len = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 0, in_ready, busy, done, error, flash_cs_n, sh_start;
  logic [7:0] sh_tx;
  logic sh_done = 0;
  logic [7:0] sh_rx = '0;

  always #5 clk = ~clk;

  spi_page_writer #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .start_len(start_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .busy(busy), .done(done),
    .error(error), .flash_cs_n(flash_cs_n), .sh_start(sh_start), .sh_tx(sh_tx),
    .sh_done(sh_done), .sh_rx(sh_rx)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- flash responder ----------------
  logic [7:0] mem [0:MEM_N-1];
  logic [7:0] mbuf [0:299];
  int  cnt, lat, busy_cnt, n_wren, n_rdsr, n_prog, n_win, seq_err, cross_err;
  int  overlap_err, other_err, ready_err;
  int  log_addr [0:15];
  int  log_len  [0:15];
  bit  wel, block_wel, stuck, prev_cs;
  logic [7:0] prev1, prev2, pend_rx;

  task automatic model_clear();
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
    n_wren = 0; n_rdsr = 0; n_prog = 0; n_win = 0; seq_err = 0; cross_err = 0;
    overlap_err = 0; other_err = 0; ready_err = 0; busy_cnt = 0; wel = 0;
    prev1 = 8'h00; prev2 = 8'h00;
  endtask

  task automatic close_cmd();
    int a, n;
    case (mbuf[0])
      8'h06: begin n_wren++; if (!block_wel) wel = 1; end
      8'h05: n_rdsr++;
      8'h02: begin
        if (!(prev1 == 8'h05 && prev2 == 8'h06) || !wel) seq_err++;
        a = {mbuf[1], mbuf[2], mbuf[3]};
        n = cnt - 4;
        if (n < 1 || n > 256 || (a % 256) + n > 256) cross_err++;
        if (n_prog < 16) begin log_addr[n_prog] = a; log_len[n_prog] = n; end
        n_prog++;
        for (int i = 0; i < n && i < 296; i++) mem[(a + i) % MEM_N] = mbuf[4 + i];
        wel = 0;
        busy_cnt = POLL_BUSY;
      end
      default: other_err++;
    endcase
    prev2 = prev1; prev1 = mbuf[0];
  endtask

  always @(negedge clk) begin
    if (rst) begin
      cnt = 0; lat = 0; prev_cs = 1; sh_done = 0;
    end else begin
      sh_done = 0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin sh_done = 1; sh_rx = pend_rx; end
      end
      if (sh_start) begin
        if (lat > 0 || flash_cs_n) overlap_err++;
        if (cnt < 300) mbuf[cnt] = sh_tx;
        if (cnt == 1 && mbuf[0] == 8'h05) begin
          pend_rx = {6'b0, wel, (stuck || busy_cnt > 0)};
          if (busy_cnt > 0) busy_cnt--;
        end else pend_rx = 8'hFF;
        cnt++;
        lat = 2;
      end
      if (in_ready && flash_cs_n) ready_err++;
      if (prev_cs && !flash_cs_n) n_win++;
      if (!prev_cs && flash_cs_n) begin close_cmd(); cnt = 0; end
      prev_cs = flash_cs_n;
    end
  end

  // ---------------- host stream feeder ----------------
  int feed_n = 0, feed_idx = 0, stall_ctr = 0;
  bit feed_on = 0, feed_stall = 0, hs_pend = 0;
  logic [7:0] feed_seed = 0;

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7) ^ 8'(i >> 8);
  endfunction

  always @(negedge clk) begin
    if (hs_pend) feed_idx++;
    stall_ctr++;
    if (feed_on && feed_idx < feed_n && !(feed_stall && (stall_ctr % 3 == 0))) begin
      in_valid = 1; in_data = pat(feed_seed, feed_idx);
    end else in_valid = 0;
    hs_pend = in_valid && in_ready;
  end

  // ---------------- helpers ----------------
  bit got_done, got_err;

  task automatic launch(input int addr, input int len, input logic [7:0] seed, input bit stall);
    model_clear();
    feed_n = len; feed_idx = 0; feed_seed = seed; feed_stall = stall; feed_on = 1;
    @(negedge clk);
    start = 1; start_addr = 24'(addr); start_len = 16'(len);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end();
    got_done = 0; got_err = 0;
    for (int i = 0; i < 60000 && !got_done && !got_err; i++) begin
      @(negedge clk);
      got_done = done; got_err = error;
    end
    feed_on = 0;
    @(negedge clk);
  endtask

  task automatic check_write(input string tag, input int addr, input int len, input logic [7:0] seed);
    int a = addr, rem = len, k = 0, c, bad = 0;
    chk(got_done && !got_err, "R6", {tag, " done pulse"}, got_done, 1);
    chk(!busy, "R11", {tag, " busy low after done"}, busy, 0);
    while (rem > 0) begin
      c = (rem < 256 - (a % 256)) ? rem : 256 - (a % 256);
      if (k < 16 && (log_addr[k] != a || log_len[k] != c)) begin
        bad++;
        $display("FAIL R3 %s chunk %0d actual=%0d/%0d expected=%0d/%0d",
                 tag, k, log_addr[k], log_len[k], a, c);
      end
      a += c; rem -= c; k++;
    end
    chk(bad == 0 && n_prog == k, "R3", {tag, " chunk count"}, n_prog, k);
    chk(cross_err == 0, "R3", {tag, " page crossing"}, cross_err, 0);
    chk(seq_err == 0 && n_wren == k, "R2", {tag, " enable/check before program"}, seq_err, 0);
    chk(n_rdsr == k * (POLL_BUSY + 2), "R6", {tag, " status reads"}, n_rdsr, k * (POLL_BUSY + 2));
    chk(n_win == k * (POLL_BUSY + 4) && overlap_err == 0 && other_err == 0, "R4",
        {tag, " select windows"}, n_win, k * (POLL_BUSY + 4));
    bad = 0;
    for (int i = 0; i < len; i++) if (mem[(addr + i) % MEM_N] !== pat(seed, i)) bad++;
    chk(bad == 0, "R8", {tag, " data image"}, bad, 0);
    chk(feed_idx == len && ready_err == 0, "R8", {tag, " bytes consumed"}, feed_idx, len);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!busy && !done && !error, "R1", "reset outputs", {busy, done, error}, 0);
    chk(flash_cs_n && !sh_start && !in_ready, "R1", "reset bus", {flash_cs_n, sh_start, in_ready}, 4);
  endtask

  task automatic t_one_page();
    launch(32'h100, 16, 8'h11, 0); wait_end();
    check_write("aligned16", 32'h100, 16, 8'h11);
  endtask

  task automatic t_cross_and_restart();
    launch(32'hF0, 40, 8'h22, 0);
    repeat (5) @(negedge clk);
    chk(busy, "R10", "busy while running", busy, 1);
    start = 1; start_addr = 24'h800; start_len = 16'd5;
    @(negedge clk); start = 0;
    wait_end();
    check_write("cross40", 32'hF0, 40, 8'h22);
    chk(mem[12'h800] == 8'h00 && n_prog == 2, "R10", "second start ignored", n_prog, 2);
  endtask

  task automatic t_long_stall();
    launch(32'h305, 600, 8'h5A, 1); wait_end();
    check_write("long600", 32'h305, 600, 8'h5A);
  endtask

  task automatic t_full_page();
    launch(32'h200, 256, 8'hC3, 0); wait_end();
    check_write("page256", 32'h200, 256, 8'hC3);
  endtask

  task automatic t_zero();
    model_clear();
    @(negedge clk);
    start = 1; start_addr = 24'h40; start_len = 16'd0;
    @(negedge clk); start = 0;
    chk(done && !busy, "R9", "zero length done", done, 1);
    @(negedge clk);
    chk(!done, "R11", "done single cycle", done, 0);
    repeat (10) @(negedge clk);
    chk(n_win == 0 && !busy, "R9", "zero length no bus", n_win, 0);
  endtask

  task automatic t_wel_fail();
    block_wel = 1;
    launch(32'h100, 8, 8'h01, 0); wait_end();
    block_wel = 0;
    chk(got_err && !got_done, "R5", "error on WEL clear", got_err, 1);
    chk(n_prog == 0 && n_wren == 1 && n_rdsr == 1, "R5", "no program sent", n_prog, 0);
    chk(!busy && flash_cs_n, "R11", "idle after error", busy, 0);
  endtask

  task automatic t_stuck();
    stuck = 1;
    launch(32'h000, 4, 8'h77, 0); wait_end();
    stuck = 0;
    chk(got_err && !got_done, "R7", "timeout error", got_err, 1);
    chk(n_prog == 1 && n_rdsr > 10, "R7", "polled before timeout", n_rdsr, 11);
    chk(!busy, "R7", "busy low after timeout", busy, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    block_wel = 0; stuck = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_one_page();
    t_cross_and_restart();
    t_long_stall();
    t_full_page();
    t_zero();
    t_wel_fail();
    t_stuck();
    t_one_page();
    finish_run();
  end
endmodule